// File: doc/BRIEF.md
# SPI Command Port for a UART Controller

This block is the host-facing half of a serial UART controller. A host reaches it over a 16-bit SPI slave link. The two most significant bits of each frame select one of four operations: configuration write, configuration read, data write or data read. The block holds the line configuration and the interrupt-mask register, as well as the request-to-send output bit. It hands transmit words and clear/pop strobes to the UART core. It builds the serial reply word from the core's status, and it drives an active-low interrupt line from four masked status sources.

All SPI pins are sampled on the system clock. They are assumed to be synchronised upstream, and SCLK edges are found by comparing each pin with its previous sample. An operation takes effect only on the chip-select rising edge that ends a frame of exactly 16 bits. The one exception is the interrupt mask, which is loaded as soon as the 16th bit of a configuration write has been captured. Line configuration is held back while the core reports a transmission in progress.

Top module: `spi_cmd_port`

## Requirements
- R1: `spi_mosi` is captured on rising SCLK and `spi_miso` changes on falling SCLK, most significant bit first. Frame bits 15:14 choose the operation: 2'b11 configuration write, 2'b01 configuration read, 2'b10 data write, 2'b00 data read.
- R2: A frame whose rising SCLK count at the chip-select rising edge is not exactly 16 changes no register and produces no strobe.
- R3: Reply bit 15 is the receive-available status and bit 14 is the transmit-empty status, both taken when chip select falls. Bit 15 is on `spi_miso` before the first rising SCLK. `spi_miso_oe` is low while chip select is high.
- R4: For data reads and data writes, reply bits 13:11 are 0, bit 10 is the framing/activity flag, bit 9 is the inverse of `cts_n_pin`, bit 8 is the oldest received extra bit and bits 7:0 are the received data.
- R5: For configuration reads, reply bit 13 is `cfg_o[9]`, bit 12 is `st_shutdown`, bits 11:8 are `mask_o[3:0]` and bits 7:0 are `cfg_o[7:0]`. For configuration writes, reply bits 13:0 are 0.
- R6: A configuration write sets `cfg_o` = {bit13 FIFO disable, bit12 shutdown request, bit7 IrDA, bit6 two stop bits, bit5 extra-bit enable, bit4 7-bit length, bits3:0 baud code}. It pulses `cfg_clr_o` for one cycle. The new `cfg_o` value is applied only in a cycle where `st_tx_busy` is low, and is held pending otherwise.
- R7: `mask_o` = frame bits 11:8 (T, R, extra bit, framing/activity) is loaded right after the 16th rising SCLK of a configuration write, before chip select rises, and regardless of `st_tx_busy`.
- R8: On a data write with bit 10 (TE) = 0, the block pulses `tx_load_o` for one cycle with `tx_word_o` = frame bits 8:0. With TE = 1, no load happens.
- R9: A data write stores bit 9, and `rts_n_o` is its inverse. Reset leaves `rts_n_o` high.
- R10: A data read pulses `rx_pop_o` for one cycle and clears the latched transmit-empty interrupt source.
- R11: `irq_n_o` is low exactly when any source in {T latch, `st_rx_avail`, `st_rx_extra`, `st_rx_flag`} has its mask bit set. The T latch sets when `st_tx_empty` rises and is 0 after reset.
- R12: After reset, `cfg_o` and `mask_o` are 0, `rts_n_o` and `irq_n_o` are 1 and `spi_miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| st_tx_empty | input | 1 | Core transmit buffer empty |
| st_tx_busy | input | 1 | Core transmission in progress |
| st_rx_avail | input | 1 | Core receive data available |
| st_rx_extra | input | 1 | Oldest received extra bit |
| st_rx_flag | input | 1 | Framing error / receive activity |
| st_rx_data | input | 8 | Oldest received data |
| st_shutdown | input | 1 | Core is shut down |
| cts_n_pin | input | 1 | Clear-to-send pin, active low |
| cfg_o | output | 10 | Applied line configuration |
| mask_o | output | 4 | Interrupt masks {T,R,extra,flag} |
| cfg_clr_o | output | 1 | Configuration-write clear strobe |
| tx_load_o | output | 1 | Transmit load strobe |
| tx_word_o | output | 9 | {extra bit, data} to transmit |
| rx_pop_o | output | 1 | Receive pop strobe |
| rts_n_o | output | 1 | Request-to-send pin |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
Sixteen configuration words are swept. Each uses distinct patterns in every field, so a swapped or misplaced bit shows up both on `cfg_o` and in the read-back reply. The interrupt is checked over all 256 combinations of four masks and four sources, which separates an AND/OR mix-up or a wrong mask order from correct gating. The frame-length cases (15 and 17 bits) and the deferred configuration under a busy transmitter show whether commit waits for a full frame and whether the two update timings are kept apart. Data replies are swept with alternating flag, CTS and extra-bit values against changing data bytes, which catches field-position and inversion errors.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [1:0] {
    OP_RD_DATA = 2'b00,
    OP_RD_CFG  = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_WR_CFG  = 2'b11
  } op_e;

  localparam int FRAME_W = 16;
  localparam int CFG_W   = 10;
  localparam int MASK_W  = 4;
  localparam int DATA_W  = 8;

  // configuration fields kept from a write frame
  function automatic logic [CFG_W-1:0] pick_cfg(input logic [FRAME_W-1:0] w);
    return {w[13], w[12], w[7:0]};
  endfunction

  // low 14 reply bits of a data operation
  function automatic logic [FRAME_W-3:0] data_reply(input logic flag, input logic cts,
      input logic extra, input logic [DATA_W-1:0] data);
    return {3'b000, flag, cts, extra, data};
  endfunction

  // low 14 reply bits of a configuration read
  function automatic logic [FRAME_W-3:0] cfg_reply(input logic [CFG_W-1:0] cfg,
      input logic sdown, input logic [MASK_W-1:0] mask);
    return {cfg[9], sdown, mask, cfg[7:0]};
  endfunction

  function automatic logic irq_any(input logic [MASK_W-1:0] src, input logic [MASK_W-1:0] mask);
    return |(src & mask);
  endfunction
endpackage

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
  import spi_cmd_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  input  logic [1:0]    rt_i,
  input  logic [FW-3:0] reply_lo_i,
  output logic [1:0]    early_op_o,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic          frame_done_o,
  output logic [FW-1:0] word_o,
  output logic          last_edge_o,
  output logic [1:0]    nxt_op_o,
  output logic [3:0]    nxt_mask_o
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FW + 1);

  logic             sclk_q, cs_q, oe_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FW-1:0]    sh_q, out_q, nxt;
  logic             cs_fall, cs_rise, sclk_rise, sclk_fall;

  assign cs_fall   = !cs_n && cs_q;
  assign cs_rise   = cs_n && !cs_q;
  assign sclk_rise = !cs_n && !cs_q && sclk && !sclk_q;
  assign sclk_fall = !cs_n && !cs_q && !sclk && sclk_q;
  assign nxt       = {sh_q[FW-2:0], mosi};

  assign early_op_o   = {sh_q[0], mosi};
  assign last_edge_o  = sclk_rise && (cnt_q == CNT_FULL - 1'b1);
  assign nxt_op_o     = nxt[FW-1:FW-2];
  assign nxt_mask_o   = nxt[FW-5:FW-8];
  assign frame_done_o = cs_rise && (cnt_q == CNT_FULL);
  assign word_o       = sh_q;
  assign miso_o       = out_q[FW-1];
  assign miso_oe_o    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      oe_q   <= 1'b0;
      cnt_q  <= CNT_OVER;
      sh_q   <= '0;
      out_q  <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_fall) begin
        cnt_q <= '0;
        oe_q  <= 1'b1;
        out_q <= {rt_i, {(FW-2){1'b0}}};
      end else if (cs_n) begin
        oe_q <= 1'b0;
      end else if (sclk_rise) begin
        if (cnt_q < CNT_FULL) sh_q <= nxt;
        if (cnt_q <= CNT_FULL) cnt_q <= cnt_q + 1'b1;
        // operation known at second edge: fill in the body of the reply
        if (cnt_q == CNT_W'(1)) out_q <= {out_q[FW-1], reply_lo_i, 1'b0};
      end else if (sclk_fall) begin
        out_q <= {out_q[FW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int CW = CFG_W,
  parameter int MW = MASK_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done_i,
  input  logic [FW-1:0] word_i,
  input  logic          last_edge_i,
  input  logic [1:0]    nxt_op_i,
  input  logic [MW-1:0] nxt_mask_i,
  input  logic          tx_busy_i,
  output logic [CW-1:0] cfg_o,
  output logic [MW-1:0] mask_o,
  output logic          rts_o,
  output logic          cfg_clr_o,
  output logic          tx_load_o,
  output logic [DW:0]   tx_word_o,
  output logic          rx_pop_o,
  output logic          mask_hit_o
);
  op_e          op;
  logic         pend_q;
  logic [CW-1:0] pend_cfg_q;

  assign op         = op_e'(word_i[FW-1:FW-2]);
  assign mask_hit_o = last_edge_i && (op_e'(nxt_op_i) == OP_WR_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o      <= '0;
      mask_o     <= '0;
      rts_o      <= 1'b0;
      cfg_clr_o  <= 1'b0;
      tx_load_o  <= 1'b0;
      tx_word_o  <= '0;
      rx_pop_o   <= 1'b0;
      pend_q     <= 1'b0;
      pend_cfg_q <= '0;
    end else begin
      cfg_clr_o <= frame_done_i && (op == OP_WR_CFG);
      rx_pop_o  <= frame_done_i && (op == OP_RD_DATA);
      tx_load_o <= frame_done_i && (op == OP_WR_DATA) && !word_i[10];
      if (mask_hit_o) mask_o <= nxt_mask_i;
      if (frame_done_i && op == OP_WR_CFG) begin
        mask_o     <= word_i[11:8];
        pend_cfg_q <= pick_cfg(word_i);
        pend_q     <= 1'b1;
      end else if (pend_q && !tx_busy_i) begin
        cfg_o  <= pend_cfg_q;
        pend_q <= 1'b0;
      end
      if (frame_done_i && op == OP_WR_DATA) begin
        rts_o <= word_i[9];
        if (!word_i[10]) tx_word_o <= word_i[DW:0];
      end
    end
  end
endmodule

// File: rtl/spi_cmd_irq.sv
module spi_cmd_irq
  import spi_cmd_pkg::*;
#(
  parameter int MW = MASK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_empty_i,
  input  logic          rx_avail_i,
  input  logic          rx_extra_i,
  input  logic          rx_flag_i,
  input  logic          rd_clear_i,
  input  logic [MW-1:0] mask_i,
  output logic          irq_req_o,
  output logic          irq_n_o
);
  logic te_q, tsrc_q;

  assign irq_req_o = irq_any({tsrc_q, rx_avail_i, rx_extra_i, rx_flag_i}, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q    <= 1'b1;
      tsrc_q  <= 1'b0;
      irq_n_o <= 1'b1;
    end else begin
      te_q    <= tx_empty_i;
      irq_n_o <= !irq_req_o;
      if (rd_clear_i) tsrc_q <= 1'b0;
      else if (tx_empty_i && !te_q) tsrc_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_cmd_port.sv
module spi_cmd_port
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              st_tx_empty,
  input  logic              st_tx_busy,
  input  logic              st_rx_avail,
  input  logic              st_rx_extra,
  input  logic              st_rx_flag,
  input  logic [DATA_W-1:0] st_rx_data,
  input  logic              st_shutdown,
  input  logic              cts_n_pin,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              cfg_clr_o,
  output logic              tx_load_o,
  output logic [DATA_W:0]   tx_word_o,
  output logic              rx_pop_o,
  output logic              rts_n_o,
  output logic              irq_n_o
);
  logic [1:0]         early_op, nxt_op;
  logic [MASK_W-1:0]  nxt_mask;
  logic [FRAME_W-3:0] reply_lo;
  logic [FRAME_W-1:0] frame_word;
  logic               frame_done, last_edge, mask_hit, rts_q, irq_req;
  logic [1:0]         frame_op;

  assign frame_op = frame_word[FRAME_W-1:FRAME_W-2];

  always_comb begin
    case (op_e'(early_op))
      OP_RD_CFG: reply_lo = cfg_reply(cfg_o, st_shutdown, mask_o);
      OP_WR_CFG: reply_lo = '0;
      default:   reply_lo = data_reply(st_rx_flag, !cts_n_pin, st_rx_extra, st_rx_data);
    endcase
  end

  spi_cmd_frame #(.FW(FRAME_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .rt_i({st_rx_avail, st_tx_empty}), .reply_lo_i(reply_lo), .early_op_o(early_op),
    .miso_o(spi_miso), .miso_oe_o(spi_miso_oe), .frame_done_o(frame_done),
    .word_o(frame_word), .last_edge_o(last_edge), .nxt_op_o(nxt_op), .nxt_mask_o(nxt_mask)
  );

  spi_cmd_regs #(.FW(FRAME_W), .CW(CFG_W), .MW(MASK_W), .DW(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done), .word_i(frame_word),
    .last_edge_i(last_edge), .nxt_op_i(nxt_op), .nxt_mask_i(nxt_mask),
    .tx_busy_i(st_tx_busy), .cfg_o(cfg_o), .mask_o(mask_o), .rts_o(rts_q),
    .cfg_clr_o(cfg_clr_o), .tx_load_o(tx_load_o), .tx_word_o(tx_word_o),
    .rx_pop_o(rx_pop_o), .mask_hit_o(mask_hit)
  );

  spi_cmd_irq #(.MW(MASK_W)) irq_i (
    .clk(clk), .rst_n(rst_n), .tx_empty_i(st_tx_empty), .rx_avail_i(st_rx_avail),
    .rx_extra_i(st_rx_extra), .rx_flag_i(st_rx_flag), .rd_clear_i(rx_pop_o),
    .mask_i(mask_o), .irq_req_o(irq_req), .irq_n_o(irq_n_o)
  );

  assign rts_n_o = !rts_q;
endmodule

// File: rtl/spi_cmd_port_chk.sv
module spi_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso_oe,
  input logic [9:0] cfg_o,
  input logic [3:0] mask_o,
  input logic       st_tx_busy,
  input logic       rts_n_o,
  input logic       tx_load_o,
  input logic       rx_pop_o,
  input logic       cfg_clr_o,
  input logic       frame_done,
  input logic [1:0] frame_op,
  input logic       mask_hit,
  input logic       irq_req,
  input logic       irq_n_o
);
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_load_o, rx_pop_o, cfg_clr_o}));
  p_commit_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_o || rx_pop_o || cfg_clr_o) |-> $past(frame_done));
  p_oe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_miso_oe);
  p_cfg_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> !$past(st_tx_busy));
  p_mask_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_o) |-> $past(mask_hit));
  p_rts_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rts_n_o) |-> $past(frame_done && frame_op == 2'b10));
  p_irq_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_n_o);
endmodule

bind spi_cmd_port spi_cmd_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .cfg_o(cfg_o), .mask_o(mask_o), .st_tx_busy(st_tx_busy), .rts_n_o(rts_n_o),
  .tx_load_o(tx_load_o), .rx_pop_o(rx_pop_o), .cfg_clr_o(cfg_clr_o),
  .frame_done(frame_done), .frame_op(frame_op), .mask_hit(mask_hit),
  .irq_req(irq_req), .irq_n_o(irq_n_o)
);

// File: tb/spi_cmd_port_tb.sv
`timescale 1ns/1ps
module spi_cmd_port_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe;
  logic       st_tx_empty = 1'b1, st_tx_busy = 1'b0, st_rx_avail = 1'b0;
  logic       st_rx_extra = 1'b0, st_rx_flag = 1'b0, st_shutdown = 1'b0, cts_n_pin = 1'b1;
  logic [7:0] st_rx_data = 8'h00;
  logic [9:0] cfg_o;
  logic [3:0] mask_o;
  logic       cfg_clr_o, tx_load_o, rx_pop_o, rts_n_o, irq_n_o;
  logic [8:0] tx_word_o;

  int errors = 0, checks = 0;
  int n_clr = 0, n_load = 0, n_pop = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_cmd_port dut_i (.*);

  always @(posedge clk) begin
    if (cfg_clr_o) n_clr++;
    if (tx_load_o) n_load++;
    if (rx_pop_o) n_pop++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits, input bit fin, output logic [15:0] r);
    r = '0;
    spi_cs_n = 1'b0;
    wait_clk(3);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(3);
      if (i < 16) r[15-i] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(3);
      spi_sclk = 1'b0;
    end
    wait_clk(3);
    if (fin) begin
      spi_cs_n = 1'b1;
      wait_clk(4);
    end
  endtask

  function automatic logic [15:0] exp_data(input logic [7:0] d);
    return {st_rx_avail, st_tx_empty, 3'b000, st_rx_flag, ~cts_n_pin, st_rx_extra, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r, w;
    logic [9:0]  ecfg;
    int          c0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R12 reset state
    chk(cfg_o == 0 && mask_o == 0, "R12 cfg/mask", {cfg_o, mask_o}, 0);
    chk(rts_n_o && irq_n_o && !spi_miso_oe, "R12 pins", {rts_n_o, irq_n_o, spi_miso_oe}, 3'b110);

    // R3: first reply bit present before the first rising edge, oe follows cs
    st_rx_avail = 1'b1;
    spi_cs_n = 1'b0;
    wait_clk(3);
    chk(spi_miso == 1'b1 && spi_miso_oe, "R3 early bit15", {spi_miso, spi_miso_oe}, 2'b11);
    spi_cs_n = 1'b1;
    wait_clk(3);
    chk(!spi_miso_oe, "R3 oe idle", spi_miso_oe, 0);
    st_rx_avail = 1'b0;

    // R6 R7 R5: configuration sweep, written and read back
    for (int i = 0; i < 16; i++) begin
      w = {2'b11, i[0], i[1], i[3:0], i[2], i[0], i[3], i[1], 4'(15 - i)};
      ecfg = {w[13], w[12], w[7:0]};
      c0 = n_clr;
      xfer(w, 16, 1'b1, r);
      chk(r == {st_rx_avail, st_tx_empty, 14'b0}, "R5 wcfg reply", r, {st_rx_avail, st_tx_empty, 14'b0});
      chk(cfg_o == ecfg, "R6 cfg value", cfg_o, ecfg);
      chk(mask_o == w[11:8], "R7 mask value", mask_o, w[11:8]);
      chk(n_clr == c0 + 1, "R6 clear strobe", n_clr, c0 + 1);
      st_shutdown = i[2];
      xfer(16'h4000, 16, 1'b1, r);
      chk(r == {1'b0, st_tx_empty, ecfg[9], st_shutdown, w[11:8], ecfg[7:0]}, "R5 rcfg reply", r,
          {1'b0, st_tx_empty, ecfg[9], st_shutdown, w[11:8], ecfg[7:0]});
    end
    st_shutdown = 1'b0;
    xfer(16'hC000, 16, 1'b1, r);

    // R2: short configuration frame discarded
    c0 = n_clr;
    xfer(16'hFFFF, 15, 1'b1, r);
    wait_clk(4);
    chk(cfg_o == 0 && mask_o == 0 && n_clr == c0, "R2 short frame", {cfg_o, mask_o}, 0);
    // R2: long data frame discarded
    c0 = n_load;
    xfer(16'h8255, 17, 1'b1, r);
    chk(n_load == c0 && rts_n_o, "R2 long frame", {n_load, rts_n_o}, {c0, 1'b1});

    // R7 mask live before cs rise and while busy; R6 config deferred
    st_tx_busy = 1'b1;
    xfer(16'hC5A3, 16, 1'b0, r);
    chk(mask_o == 4'h5, "R7 mask at edge16", mask_o, 4'h5);
    spi_cs_n = 1'b1;
    wait_clk(8);
    chk(cfg_o == 0, "R6 held while busy", cfg_o, 0);
    st_tx_busy = 1'b0;
    wait_clk(3);
    chk(cfg_o == {1'b0, 1'b0, 8'hA3}, "R6 applied when idle", cfg_o, {2'b00, 8'hA3});
    xfer(16'hC000, 16, 1'b1, r);

    // R8 R9: data writes
    c0 = n_load;
    xfer(16'h83A5, 16, 1'b1, r);
    chk(n_load == c0 + 1 && tx_word_o == 9'h1A5, "R8 load", {n_load, tx_word_o}, {c0 + 1, 9'h1A5});
    chk(!rts_n_o, "R9 rts set", rts_n_o, 0);
    c0 = n_load;
    xfer(16'h8455, 16, 1'b1, r);
    chk(n_load == c0 && tx_word_o == 9'h1A5, "R8 TE inhibits", {n_load, tx_word_o}, {c0, 9'h1A5});
    chk(rts_n_o, "R9 rts clear via TE frame", rts_n_o, 1);

    // R4 R1 R10: data replies
    for (int i = 0; i < 8; i++) begin
      st_rx_flag  = i[0];
      cts_n_pin   = i[1];
      st_rx_extra = i[2];
      st_rx_avail = i[0] ^ i[2];
      st_rx_data  = 8'(8'h3C * i + 8'h81);
      c0 = n_pop;
      xfer(16'h0000, 16, 1'b1, r);
      chk(r == exp_data(st_rx_data), "R4 read reply", r, exp_data(st_rx_data));
      chk(n_pop == c0 + 1, "R10 pop strobe", n_pop, c0 + 1);
      xfer(16'h8400, 16, 1'b1, r);
      chk(r == exp_data(st_rx_data), "R1 write-data reply", r, exp_data(st_rx_data));
    end
    st_rx_flag = 0; st_rx_extra = 0; st_rx_avail = 0; cts_n_pin = 1;

    // R11 R10: all mask x source combinations
    for (int m = 0; m < 16; m++) begin
      xfer({2'b11, 2'b00, 4'(m), 8'h00}, 16, 1'b1, r);
      for (int s = 0; s < 16; s++) begin
        st_rx_avail = s[2];
        st_rx_extra = s[1];
        st_rx_flag  = s[0];
        if (s[3]) begin
          st_tx_empty = 1'b0;
          wait_clk(2);
          st_tx_empty = 1'b1;
        end else begin
          xfer(16'h0000, 16, 1'b1, r);
        end
        wait_clk(3);
        chk(irq_n_o == !(|(s[3:0] & m[3:0])), "R11 irq", irq_n_o, !(|(s[3:0] & m[3:0])));
      end
    end
    // R10: data read clears T source
    st_rx_avail = 0; st_rx_extra = 0; st_rx_flag = 0;
    xfer(16'h0000, 16, 1'b1, r);
    wait_clk(3);
    chk(irq_n_o && st_tx_empty, "R10 T source cleared", irq_n_o, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule